// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block sits on the host side of an 8-bit serial analog-to-digital converter that is controlled by a chip select and a single transfer clock, and that returns its result on one serial data line. When the host raises a read request, the block pulls chip select low and waits a programmable number of host clock cycles. It then drives exactly eight transfer clock pulses and collects one bit per pulse, most significant bit first. At the falling edge of the eighth pulse it releases chip select and presents the assembled byte with a one-cycle valid strobe.

The converter returns the result of the conversion started by the previous frame, and the last falling clock edge of every frame starts a new conversion. For this reason the block keeps chip select high for a programmable conversion wait after each frame, and it marks the first byte after reset as stale because no earlier conversion exists. A request that arrives while a frame or the conversion wait is in progress is remembered and served once the wait ends. All timing figures are counts of the host clock.

Top module: `serial_adc_reader`

## Requirements
- R1: While reset is high and in the cycle after it falls, chip select (`adc_cs_n`) is high (inactive), the transfer clock (`adc_sclk`) is low, and `rd_valid` and `rd_stale` are low.
- R2: A request seen by the block in IDLE pulls `adc_cs_n` low at the next clock edge, and `adc_cs_n` stays low for exactly `SETUP_CYC` host cycles before `adc_sclk` first rises.
- R3: Each frame has exactly eight `adc_sclk` pulses, each high for `HI_CYC` cycles, separated by low phases of `LO_CYC` cycles; `adc_sclk` is low whenever `adc_cs_n` is high.
- R4: The bit on `adc_sdo` in the last cycle of each high phase is captured; the first captured bit lands in `rd_data[7]` and the eighth in `rd_data[0]`.
- R5: At the clock edge where the eighth pulse falls, `adc_cs_n` rises and `rd_valid` is high for exactly one cycle with the new byte on `rd_data`.
- R6: After a frame, `adc_cs_n` stays high for at least `CONV_CYC` host cycles before it falls again.
- R7: A request that arrives during a frame or the conversion wait is held and starts exactly one further frame after the wait; several such requests merge into one.
- R8: `rd_stale` is high together with the first `rd_valid` after reset, and low with every later one.
- R9: `rd_data` keeps its value in every cycle where `rd_valid` is low.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request, one cycle or held |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_sclk | output | 1 | Transfer clock, idles low |
| rd_data | output | 8 | Byte from the last frame |
| rd_valid | output | 1 | One-cycle strobe for a new byte |
| rd_stale | output | 1 | The byte with this strobe has no prior conversion behind it |

## Verification
The two functions that can fall in the same cycle are the acceptance of a new request and the end of a frame or of its conversion wait: a request can arrive at the very edge where the eighth pulse falls, or at the edge where the wait expires. The bench provokes this by pulsing requests in the middle of frames and conversion waits and by holding the request high across several frames, and judges it by counting frames (one extra frame per merged burst, none lost) while checking that every chip-select gap still covers the conversion time. Returned bytes are compared against a converter model that serves the value latched by the previous frame.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_HIGH  = 3'd2,
        ST_LOW   = 3'd3,
        ST_CONV  = 3'd4
    } rd_state_e;

    // Pin levels driven toward the converter
    typedef struct packed {
        logic cs_n;
        logic sclk;
    } adc_pins_t;

    localparam adc_pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b0};

    // Width able to hold the largest of four counts
    function automatic int unsigned cnt_width(input int unsigned a,
                                              input int unsigned b,
                                              input int unsigned c,
                                              input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return (m < 2) ? 1 : $clog2(m + 1);
    endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (en) begin
            word <= {word[W-2:0], din};
        end
    end
endmodule

// File: rtl/serial_adc_reader.sv
module serial_adc_reader
    import adc_rd_pkg::*;
#(
    parameter int unsigned BITS      = 8,
    parameter int unsigned SETUP_CYC = 3,
    parameter int unsigned HI_CYC    = 2,
    parameter int unsigned LO_CYC    = 2,
    parameter int unsigned CONV_CYC  = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_req,
    input  logic            adc_sdo,
    output logic            adc_cs_n,
    output logic            adc_sclk,
    output logic [BITS-1:0] rd_data,
    output logic            rd_valid,
    output logic            rd_stale
);
    localparam int unsigned CW = cnt_width(SETUP_CYC, HI_CYC, LO_CYC, CONV_CYC);
    localparam int unsigned BW = $clog2(BITS + 1);
    localparam logic [CW-1:0] LD_SETUP = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] LD_HI    = CW'(HI_CYC - 1);
    localparam logic [CW-1:0] LD_LO    = CW'(LO_CYC - 1);
    localparam logic [CW-1:0] LD_CONV  = CW'(CONV_CYC - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(BITS - 1);

    rd_state_e       state;
    adc_pins_t       pins;
    logic [BW-1:0]   bit_idx;
    logic            pend;
    logic            seen;
    logic            start;
    logic            last_bit;
    logic            tmr_load;
    logic [CW-1:0]   tmr_val;
    logic            tmr_zero;
    logic            shift_en;
    logic [BITS-1:0] sh_word;

    assign start    = rd_req | pend;
    assign last_bit = (bit_idx == LAST_BIT);
    assign adc_cs_n = pins.cs_n;
    assign adc_sclk = pins.sclk;

    adc_rd_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    adc_rd_shifter #(.W(BITS)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .en   (shift_en),
        .din  (adc_sdo),
        .word (sh_word)
    );

    // Timer reload and capture decisions
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        shift_en = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    tmr_load = 1'b1;
                    tmr_val  = LD_SETUP;
                end
            end
            ST_SETUP, ST_LOW: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = LD_HI;
                end
            end
            ST_HIGH: begin
                if (tmr_zero) begin
                    shift_en = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = last_bit ? LD_CONV : LD_LO;
                end
            end
            default: ;
        endcase
    end

    // Frame sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pins     <= PINS_IDLE;
            bit_idx  <= '0;
            pend     <= 1'b0;
            seen     <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            rd_stale <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            rd_stale <= 1'b0;
            if (state == ST_IDLE) begin
                pend <= 1'b0;
            end else begin
                pend <= pend | rd_req;
            end
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_SETUP;
                        pins.cs_n <= 1'b0;
                        bit_idx   <= '0;
                    end
                end
                ST_SETUP, ST_LOW: begin
                    if (tmr_zero) begin
                        state     <= ST_HIGH;
                        pins.sclk <= 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (tmr_zero) begin
                        pins.sclk <= 1'b0;
                        bit_idx   <= bit_idx + 1'b1;
                        if (last_bit) begin
                            state     <= ST_CONV;
                            pins.cs_n <= 1'b1;
                            rd_data   <= {sh_word[BITS-2:0], adc_sdo};
                            rd_valid  <= 1'b1;
                            rd_stale  <= ~seen;
                            seen      <= 1'b1;
                        end else begin
                            state <= ST_LOW;
                        end
                    end
                end
                ST_CONV: begin
                    if (tmr_zero) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Observers for the properties below, independent of the sequencer
    logic [BW-1:0] mon_pulses;
    logic [CW-1:0] mon_hi_run;
    logic          mon_sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mon_pulses <= '0;
            mon_hi_run <= CW'(CONV_CYC);
            mon_sclk_q <= 1'b0;
        end else begin
            mon_sclk_q <= adc_sclk;
            if (adc_cs_n) begin
                mon_pulses <= '0;
                if (mon_hi_run < CW'(CONV_CYC)) mon_hi_run <= mon_hi_run + 1'b1;
            end else begin
                mon_hi_run <= '0;
                if (adc_sclk && !mon_sclk_q) mon_pulses <= mon_pulses + 1'b1;
            end
        end
    end

    // R3
    sclk_under_cs_chk: assert property (@(posedge clk) disable iff (rst)
        adc_sclk |-> !adc_cs_n);

    // R3
    pulse_count_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (mon_pulses == BW'(BITS)));

    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R5
    valid_with_cs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $rose(adc_cs_n));

    // R6
    conv_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_cs_n) |-> (mon_hi_run >= CW'(CONV_CYC)));

    // R8
    stale_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stale |-> rd_valid);

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> $stable(rd_data));

endmodule

// File: tb/test_serial_adc_reader.sv
module test_serial_adc_reader;
    localparam int CLK_PERIOD = 10;
    localparam int BITS  = 8;
    localparam int SETUP = 3;
    localparam int HI    = 2;
    localparam int LO    = 3;
    localparam int CONV  = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_req = 1'b0;
    logic adc_sdo = 1'b0;
    logic adc_cs_n, adc_sclk, rd_valid, rd_stale;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_adc_reader #(
        .BITS(BITS), .SETUP_CYC(SETUP), .HI_CYC(HI), .LO_CYC(LO), .CONV_CYC(CONV)
    ) i_serial_adc_reader (
        .clk(clk), .rst(rst), .rd_req(rd_req), .adc_sdo(adc_sdo),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_stale(rd_stale)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    // Converter model: serves the value latched by the previous frame
    int unsigned sample_no = 0;
    logic [7:0] adc_res = 8'h3C;
    logic [7:0] adc_sh;
    logic [7:0] exp_data;
    int adc_falls = 0;

    function automatic logic [7:0] next_sample(input int unsigned k);
        case (k)
            0: return 8'hFF;
            1: return 8'h00;
            2: return 8'hA5;
            3: return 8'h01;
            4: return 8'h80;
            default: return 8'($urandom_range(0, 255));
        endcase
    endfunction

    always @(negedge adc_cs_n) begin
        adc_sh    = adc_res;
        exp_data  = adc_res;
        adc_sdo   = adc_sh[7];
        adc_falls = 0;
    end

    always @(negedge adc_sclk) begin
        adc_falls++;
        adc_sh  = {adc_sh[6:0], 1'b0};
        adc_sdo = adc_sh[7];
        if (adc_falls == 8) begin
            adc_res = next_sample(sample_no);
            sample_no++;
        end
    end

    // Port monitor, sampled away from the active edge
    bit   mon_on = 0;
    logic p_cs = 1'b1, p_sclk = 1'b0;
    int   setup_cnt = 0, hi_cnt = 0, lo_cnt = 0, rises = 0;
    int   cs_hi_cnt = 1000;
    int   frames = 0, valids = 0;
    bit   have_data = 0;
    logic [7:0] last_data;

    always @(negedge clk) begin
        if (mon_on) begin
            if (adc_sclk && adc_cs_n) chk(0, "R3 sclk high with cs high", 1, 0);
            if (!adc_cs_n && p_cs) begin
                chk(cs_hi_cnt >= CONV, "R6 cs high gap", cs_hi_cnt, CONV);
                frames++;
                setup_cnt = 1; rises = 0; lo_cnt = 0;
            end else if (!adc_cs_n && !adc_sclk && !p_sclk && rises == 0) begin
                setup_cnt++;
            end
            if (adc_sclk && !p_sclk) begin
                if (rises == 0) chk(setup_cnt == SETUP, "R2 setup cycles", setup_cnt, SETUP);
                else chk(lo_cnt == LO, "R3 low phase", lo_cnt, LO);
                rises++; hi_cnt = 1;
            end else if (adc_sclk) begin
                hi_cnt++;
            end
            if (!adc_sclk && p_sclk) begin
                chk(hi_cnt == HI, "R3 high phase", hi_cnt, HI);
                lo_cnt = 1;
            end else if (!adc_sclk && !adc_cs_n && rises > 0) begin
                lo_cnt++;
            end
            if (adc_cs_n && !p_cs) begin
                chk(rises == 8, "R3 pulse count", rises, 8);
                cs_hi_cnt = 1;
            end else if (adc_cs_n) begin
                cs_hi_cnt++;
            end
            if (rd_valid) begin
                chk(adc_cs_n && !p_cs, "R5 valid at cs rise", adc_cs_n, 1);
                chk(rd_data == exp_data, "R4 byte msb first", rd_data, exp_data);
                chk(rd_stale == (valids == 0), "R8 stale flag", rd_stale, valids == 0);
                valids++;
                last_data = rd_data;
                have_data = 1;
            end else begin
                chk(!rd_stale, "R8 stale without valid", rd_stale, 0);
                if (have_data) chk(rd_data == last_data, "R9 data hold", rd_data, last_data);
            end
            p_cs = adc_cs_n;
            p_sclk = adc_sclk;
        end
    end

    task automatic pulse_req();
        @(negedge clk) rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
    endtask

    task automatic wait_valids(input int target);
        while (valids < target) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int f0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(adc_cs_n == 1'b1, "R1 cs in reset", adc_cs_n, 1);
        chk(adc_sclk == 1'b0, "R1 sclk in reset", adc_sclk, 0);
        chk(rd_valid == 1'b0 && rd_stale == 1'b0, "R1 strobes in reset", rd_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(adc_cs_n == 1'b1 && adc_sclk == 1'b0 && !rd_valid, "R1 after reset", adc_cs_n, 1);
        mon_on = 1;

        // First read: stale byte (R8), setup and pulses (R2, R3)
        pulse_req();
        wait_valids(1);
        repeat (2 * CONV) @(negedge clk);

        // R7: two requests inside one frame merge into one follow-up frame
        f0 = frames;
        pulse_req();
        while (adc_cs_n) @(negedge clk);
        repeat (5) @(negedge clk);
        pulse_req();
        repeat (3) @(negedge clk);
        pulse_req();
        wait_valids(3);
        repeat (3 * CONV + 60) @(negedge clk);
        chk(frames == f0 + 2, "R7 merged requests", frames - f0, 2);

        // R7: request during the conversion wait is served afterwards
        f0 = frames;
        pulse_req();
        wait_valids(4);
        repeat (4) @(negedge clk);
        pulse_req();
        repeat (3 * CONV + 60) @(negedge clk);
        chk(frames == f0 + 2, "R7 request in conversion wait", frames - f0, 2);

        // R6: request held high gives back-to-back frames with full gaps
        f0 = valids;
        @(negedge clk) rd_req = 1'b1;
        wait_valids(f0 + 3);
        @(negedge clk) rd_req = 1'b0;
        repeat (3 * CONV + 60) @(negedge clk);
        chk(adc_cs_n == 1'b1, "R7 idle after held request", adc_cs_n, 1);

        // Random spacing of requests and random converter values
        for (int i = 0; i < 40; i++) begin
            int gap;
            gap = $urandom_range(0, 30);
            repeat (gap) @(negedge clk);
            f0 = valids;
            pulse_req();
            wait_valids(f0 + 1);
            if ($urandom_range(0, 3) == 0) begin
                repeat ($urandom_range(1, CONV)) @(negedge clk);
                pulse_req();
                wait_valids(f0 + 2);
            end
        end
        repeat (3 * CONV + 60) @(negedge clk);
        finish_run();
    end
endmodule